// File: doc/BRIEF.md
# Multiplexed ADC Serial Slave Interface

This block is the digital serial port of an eight-input, 10-bit sampling converter. It acts as a slave on an SPI-style link made of an active-low chip select, a serial clock, a data input and a data output. The block runs on a fast system clock and oversamples the three serial lines through synchronizers. In each frame it takes an 8-bit control word from the data input and shifts out the result of the previous conversion on the data output.

The analog side is modelled by three signals. A parallel 10-bit sample input carries the converted value. A 3-bit channel-select output steers the input multiplexer. A one-cycle strobe marks the moment a conversion is taken. The channel address is pipelined: the address written during one frame selects the input for the conversion taken at the end of the following frame. After reset the multiplexer points at input 0, so the first conversion needs no dummy frame.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset, `chan_sel` is 0, `sdo_oe` and `sample_stb` are 0, and the stored result is 0. The first conversion is therefore taken from input 0, and the first frame shifts out an all-zero word.
- R2: The control word is the first 8 `sdi` bits sampled on rising `sclk` edges after `cs_n` falls, most significant bit first. Bits 5..3 of the word form the channel address, with bit 5 the high bit. Bits 7, 6, 2, 1 and 0 have no effect.
- R3: Address code k (000 to 111, straight binary) sets `chan_sel` to k one system clock after the strobe of the frame that carried it. Before that strobe, `chan_sel` keeps its old value for the whole frame.
- R4: A frame is 16 serial clocks. `sdo` carries 4 zeros, then the 10 result bits MSB first, then 2 zeros. Bit 0 is presented when chip select falls, and each later bit is presented after a falling `sclk` edge.
- R5: The result shifted out in a frame is the `sample_data` value latched at the strobe of the previous complete frame. That value is taken while `chan_sel` still holds the address from the frame before that one, and it is passed through unchanged as a straight binary code.
- R6: While `cs_n` is high, `sdo_oe` is 0 and `sdo` is 0. While a frame is in progress, `sdo_oe` is 1.
- R7: `sample_stb` pulses for exactly one system clock per complete frame, after the 16th rising `sclk` edge.
- R8: If `cs_n` rises before the 16th rising edge, the frame is aborted. No strobe is given, `chan_sel` is unchanged, the partly received address is discarded, and the stored result is kept for the next frame.
- R9: If `cs_n` falls while `sclk` is high, the next falling `sclk` edge does not advance the output. If `cs_n` falls while `sclk` is low, or both fall together, the chip-select fall itself is the first falling edge. In all three cases the word shifted out is the same.
- R10: Rising `sclk` edges after the 16th in the same frame have no effect. They give no second strobe and do not change the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial control data from the master |
| sample_data | input | 10 | Converted value from the analog front end |
| sdo | output | 1 | Serial result data to the master |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| chan_sel | output | 3 | Active multiplexer channel |
| sample_stb | output | 1 | One-cycle conversion strobe |

## Verification
The bench goes after the one-frame address pipeline. A design that applied the address at once would show the new channel before the strobe, and the next frame would return the wrong code. It aborts a frame after the address bits are already in. A design that kept the partial word would change channel or give a strobe that was never due. It starts frames with the serial clock high, low, and falling together with chip select. A design that treated the extra falling edge as data would shift the whole word by one bit. It also sends extra clocks past the 16th and sets every ignored control bit, to catch a second strobe or an address taken from the wrong positions.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  localparam int RES_W    = 10;  // conversion result width
  localparam int CH_W     = 3;   // channel address width
  localparam int CTRL_W   = 8;   // control word length
  localparam int ADDR_LSB = 3;   // lowest address bit inside the control word
  localparam int LEAD_Z   = 4;   // zeros before the result
  localparam int TRAIL_Z  = 2;   // zeros after the result
  localparam int SYNC_N   = 2;   // synchronizer depth
endpackage

// File: rtl/adcif_sync.sv
module adcif_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/adcif_ctl_rx.sv
module adcif_ctl_rx #(
  parameter int FRAME_LEN = 16,
  parameter int CTRL_W    = 8,
  parameter int CH_W      = 3,
  parameter int ADDR_LSB  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            act_i,
  input  logic            rise_i,
  input  logic            sdi_i,
  output logic            started_o,
  output logic            done_o,
  output logic [CH_W-1:0] addr_o
);
  localparam int CNT_W  = $clog2(FRAME_LEN + 1);
  localparam int KEEP_W = ADDR_LSB + CH_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CWN  = CNT_W'(CTRL_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [KEEP_W-1:0] keep_q, keep_d;
  logic              done_q, done_d;
  logic              cnt_en, keep_en;

  // keep only the low KEEP_W bits of the word; after CTRL_W shifts the
  // address sits at the top of the kept window
  always_comb begin
    cnt_en  = 1'b0;
    keep_en = 1'b0;
    cnt_d   = cnt_q;
    keep_d  = keep_q;
    done_d  = 1'b0;
    if (start_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (act_i && rise_i && (cnt_q < FULL)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
      done_d = (cnt_q == LAST);
      if (cnt_q < CWN) begin
        keep_en = 1'b1;
        keep_d  = {keep_q[KEEP_W-2:0], sdi_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      keep_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (keep_en) keep_q <= keep_d;
      done_q <= done_d;
    end
  end

  assign started_o = (cnt_q != '0);
  assign done_o    = done_q;
  assign addr_o    = keep_q[KEEP_W-1:ADDR_LSB];
endmodule

// File: rtl/adcif_tx.sv
module adcif_tx #(
  parameter int RES_W   = 10,
  parameter int LEAD_Z  = 4,
  parameter int TRAIL_Z = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [RES_W-1:0] res_i,
  output logic             bit_o
);
  localparam int FRAME_LEN = LEAD_Z + RES_W + TRAIL_Z;

  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic                 sh_en;

  always_comb begin
    sh_en = load_i | shift_i;
    if (load_i) sh_d = {{LEAD_Z{1'b0}}, res_i, {TRAIL_Z{1'b0}}};
    else        sh_d = {sh_q[FRAME_LEN-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign bit_o = sh_q[FRAME_LEN-1];
endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adcif_pkg::*;
#(
  parameter int P_RES_W    = RES_W,
  parameter int P_CH_W     = CH_W,
  parameter int P_CTRL_W   = CTRL_W,
  parameter int P_ADDR_LSB = ADDR_LSB,
  parameter int P_LEAD_Z   = LEAD_Z,
  parameter int P_TRAIL_Z  = TRAIL_Z,
  parameter int P_SYNC_N   = SYNC_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  input  logic [P_RES_W-1:0] sample_data,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [P_CH_W-1:0]  chan_sel,
  output logic               sample_stb
);
  localparam int FRAME_LEN = P_LEAD_Z + P_RES_W + P_TRAIL_Z;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // line synchronizers: {cs_n, sclk, sdi}, chip select idles high
  logic [2:0] lines_s;
  logic       cs_s, sclk_s, sdi_s;
  adcif_sync #(.W(3), .STAGES(P_SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d({cs_n, sclk, sdi}), .q(lines_s)
  );
  assign {cs_s, sclk_s, sdi_s} = lines_s;

  logic cs_p_q, sclk_p_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cs_p_q   <= 1'b1;
      sclk_p_q <= 1'b0;
    end else begin
      cs_p_q   <= cs_s;
      sclk_p_q <= sclk_s;
    end
  end

  logic act, cs_fall, sclk_rise, sclk_fall;
  assign act       = ~cs_s;
  assign cs_fall   = cs_p_q & ~cs_s;
  assign sclk_rise = sclk_s & ~sclk_p_q;
  assign sclk_fall = ~sclk_s & sclk_p_q;

  logic              started, done;
  logic [P_CH_W-1:0] pend_addr;
  adcif_ctl_rx #(
    .FRAME_LEN(FRAME_LEN), .CTRL_W(P_CTRL_W), .CH_W(P_CH_W), .ADDR_LSB(P_ADDR_LSB)
  ) u_rx (
    .clk(clk), .rst_n(rst_int_n), .start_i(cs_fall), .act_i(act),
    .rise_i(sclk_rise), .sdi_i(sdi_s), .started_o(started), .done_o(done),
    .addr_o(pend_addr)
  );

  // conversion state: active channel and the last result
  logic [P_CH_W-1:0]  chan_q, chan_d;
  logic [P_RES_W-1:0] res_q, res_d;
  always_comb begin
    chan_d = pend_addr;
    res_d  = sample_data;
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      chan_q <= '0;
      res_q  <= '0;
    end else if (done) begin
      chan_q <= chan_d;
      res_q  <= res_d;
    end
  end

  logic tx_bit, tx_shift;
  assign tx_shift = act & sclk_fall & started & ~cs_fall;
  adcif_tx #(.RES_W(P_RES_W), .LEAD_Z(P_LEAD_Z), .TRAIL_Z(P_TRAIL_Z)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .load_i(cs_fall), .shift_i(tx_shift),
    .res_i(res_q), .bit_o(tx_bit)
  );

  assign sdo_oe     = ~cs_p_q;
  assign sdo        = ~cs_p_q & tx_bit;
  assign chan_sel   = chan_q;
  assign sample_stb = done;
endmodule

// File: rtl/adc_serial_slave_chk.sv
module adc_serial_slave_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sdo,
  input logic            sdo_oe,
  input logic [CH_W-1:0] chan_sel,
  input logic            sample_stb,
  input logic [CH_W-1:0] pend_addr
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);                                   // R7
  AST_STB_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> sdo_oe);                                        // R7
  AST_CHAN_TAKES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (chan_sel == $past(pend_addr)));                // R3
  AST_CHAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(chan_sel));                            // R8
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);                                       // R4
endmodule

bind adc_serial_slave adc_serial_slave_chk #(.CH_W(P_CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe), .chan_sel(chan_sel),
  .sample_stb(sample_stb), .pend_addr(pend_addr)
);

// File: tb/adc_serial_slave_test.sv
module adc_serial_slave_test;
  localparam int HALF = 8;   // system clocks per serial half period

  logic       clk, rst_n, cs_n, sclk, sdi;
  logic [9:0] sample_data;
  logic       sdo, sdo_oe, sample_stb;
  logic [2:0] chan_sel;

  int total = 0, bad = 0, stb_cnt = 0;
  logic [2:0] m_chan;
  logic [9:0] m_res;

  adc_serial_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sample_data(sample_data), .sdo(sdo), .sdo_oe(sdo_oe),
    .chan_sel(chan_sel), .sample_stb(sample_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  function automatic logic [9:0] code_of(input logic [2:0] ch);
    return 10'((int'(ch) * 113) + 5);
  endfunction
  assign sample_data = code_of(chan_sel);   // analog mux model

  always @(posedge clk) if (sample_stb) stb_cnt <= stb_cnt + 1;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: sclk low at cs fall, 1: sclk high at cs fall, 2: fall together
  task automatic run_frame(input logic [7:0] ctrl, input int nclk, input int mode,
                           output logic [15:0] got, output logic [2:0] ch_mid,
                           output bit oe_all);
    got = '0; ch_mid = chan_sel; oe_all = 1'b1;
    sclk = (mode != 0); sdi = 1'b0;
    wait_clk(HALF);
    if (mode == 1) begin
      cs_n = 1'b0; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end else begin
      cs_n = 1'b0; sclk = 1'b0;
    end
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 8) ? ctrl[7-i] : 1'b1;
      wait_clk(HALF);
      if (i < 16) got[15-i] = sdo;
      if (i == 15) ch_mid = chan_sel;
      oe_all &= sdo_oe;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic full_frame(input logic [7:0] ctrl, input int nclk, input int mode, input string tag);
    logic [15:0] got; logic [2:0] mid; bit oe; int s0;
    logic [15:0] exp;
    exp = {4'b0, m_res, 2'b0};
    s0 = stb_cnt;
    run_frame(ctrl, nclk, mode, got, mid, oe);
    check(got == exp, {tag, " R4 R5 frame word"}, 32'(got), 32'(exp));
    check(mid == m_chan, {tag, " R3 channel held during frame"}, 32'(mid), 32'(m_chan));
    check(oe, {tag, " R6 output enabled in frame"}, 32'(oe), 32'd1);
    check(stb_cnt == s0 + 1, {tag, " R7 one strobe"}, 32'(stb_cnt - s0), 32'd1);
    m_res  = code_of(m_chan);
    m_chan = ctrl[5:3];
    check(chan_sel == m_chan, {tag, " R3 channel after strobe"}, 32'(chan_sel), 32'(m_chan));
  endtask

  task automatic t_reset();
    check(chan_sel == 3'd0, "R1 reset channel", 32'(chan_sel), 32'd0);
    check(sdo_oe == 1'b0, "R1 R6 reset oe", 32'(sdo_oe), 32'd0);
    check(sample_stb == 1'b0, "R1 reset strobe", 32'(sample_stb), 32'd0);
  endtask

  task automatic t_first_conv();
    full_frame(8'h28, 16, 0, "R1 first frame");   // address 5, word is zero
    full_frame(8'h10, 16, 0, "R1 input0 result"); // returns input 0 code
  endtask

  task automatic t_ignored_bits();
    full_frame(8'hD7, 16, 0, "R2 ignored bits set, addr 2");
    full_frame(8'hC7, 16, 0, "R2 ignored bits set, addr 0");
    full_frame(8'h38, 16, 0, "R2 addr 7 ignored clear");
  endtask

  task automatic t_all_channels();
    for (int k = 0; k < 8; k++) full_frame({2'b00, 3'(k), 3'b000}, 16, 0, "R3 R5 channel sweep");
    full_frame(8'h20, 16, 0, "R3 R5 sweep tail");
  endtask

  task automatic t_abort();
    logic [15:0] got; logic [2:0] mid; bit oe; int s0; logic [2:0] c0;
    s0 = stb_cnt; c0 = chan_sel;
    run_frame(8'h18, 10, 0, got, mid, oe);   // address 3, cut after 10 clocks
    check(stb_cnt == s0, "R8 no strobe on abort", 32'(stb_cnt - s0), 32'd0);
    check(chan_sel == c0, "R8 channel kept on abort", 32'(chan_sel), 32'(c0));
    full_frame(8'h08, 16, 0, "R8 result kept after abort");
  endtask

  task automatic t_extra_clocks();
    full_frame(8'h30, 20, 0, "R10 extra clocks");  // addr 6, later bits all ones
    full_frame(8'h00, 16, 0, "R10 after extra clocks");
  endtask

  task automatic t_cs_sclk_high();
    full_frame(8'h18, 16, 1, "R9 cs falls with sclk high");
    full_frame(8'h28, 16, 1, "R9 cs falls with sclk high 2");
  endtask

  task automatic t_cs_sclk_together();
    full_frame(8'h38, 16, 2, "R9 cs and sclk fall together");
    full_frame(8'h10, 16, 2, "R9 cs and sclk fall together 2");
  endtask

  task automatic t_idle_output();
    wait_clk(HALF);
    check(sdo_oe == 1'b0, "R6 oe low when deselected", 32'(sdo_oe), 32'd0);
    check(sdo == 1'b0, "R6 sdo low when deselected", 32'(sdo), 32'd0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    m_chan = 3'd0; m_res = 10'd0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);
    t_reset();
    t_first_conv();
    t_ignored_bits();
    t_idle_output();
    t_all_channels();
    t_abort();
    t_extra_clocks();
    t_cs_sclk_high();
    t_cs_sclk_together();
    t_idle_output();
    finish_run();
  end
endmodule